// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block holds a small array of words that are looked up by their content rather than by an address. A search command presents an argument word together with a key word. Every stored row is compared against the argument at the same moment, using only the bit positions where the key holds a 1. The per-row outcome is captured in a hit register that has one bit per row. Rows are loaded through a plain write port, and each row carries a valid flag that a write sets.

Software or a neighbouring engine reads the results as a stream. Starting in the cycle after the search, a scanner walks the hit register from the lowest row to the highest. It presents each matching row's index and stored word for one cycle, then pulses a completion flag. A write or a new search that arrives while the scan is running abandons the scan. The hit register keeps the result of the last search until another search replaces it.

Top module: `keyed_cam`

## Requirements
- R1: After reset no row is valid, `any_hit` is 0, and `rd_valid` and `rd_done` are both 0.
- R2: A write with `wr_en`=1 stores `wr_data` in row `wr_row` and marks that row valid. A later search returns that exact word on `rd_data` when the row matches.
- R3: A valid row matches when, for every bit j where `srch_key[j]`=1, the stored bit equals `srch_arg[j]`. Bits where the key is 0 never cause a mismatch, so an all-zero key matches every valid row.
- R4: A row that has never been written never matches, whatever the argument and key are.
- R5: `any_hit` is read in the cycle after the clock edge that samples `srch_en`=1. It is 1 exactly when at least one row matched that search.
- R6: The read-out presents matching rows in strictly ascending row order, one per cycle. The first appears one cycle after `any_hit` becomes valid. Each one asserts `rd_valid` with the row index on `rd_row` and the stored word on `rd_data`. Non-matching rows are skipped without using a cycle.
- R7: `rd_done` is high for exactly one cycle, in the cycle after the last matching row is presented. When nothing matches, it comes in the cycle where the first row would otherwise appear. `rd_valid` and `rd_done` are never high together.
- R8: A write sampled during a scan ends the scan, and no further `rd_valid` or `rd_done` follows. A search sampled during a scan restarts the read-out for the new result. When both are sampled on the same edge, the search takes precedence.
- R9: The hit register, and therefore `any_hit`, changes only on an edge that samples `srch_en`=1. Writes do not alter it, even writes that change or validate rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one row |
| wr_row | input | $clog2(WORDS) | Row index for the write |
| wr_data | input | WIDTH | Word to store |
| srch_en | input | 1 | Search command |
| srch_arg | input | WIDTH | Argument word compared against all rows |
| srch_key | input | WIDTH | Key word; 1 bits take part in the comparison |
| any_hit | output | 1 | At least one row matched the last search |
| rd_valid | output | 1 | A matching row is presented this cycle |
| rd_row | output | $clog2(WORDS) | Index of the presented row |
| rd_data | output | WIDTH | Stored word of the presented row |
| rd_done | output | 1 | One-cycle pulse ending a read-out |

## Verification
The bound checker checks these properties on every cycle:
- rows are presented in rising order within a scan;
- a presented row always has its hit bit set;
- the data and completion flags are never high together;
- a write leaves the outputs quiet on the following cycle;
- the hit register stays still unless a search was sampled.

Only the bench scenarios can show the rest, because it depends on the stored contents. This covers whether the masked comparison selects the right rows and returns the right words. It also covers invalid rows staying out of results, the last row being reached, completion arriving at the right time, and the two ways a scan can be abandoned.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_t;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
   parameter int WORDS = 8,
   parameter int WIDTH = 16,
   localparam int ROW_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] cmp_arg,
   input  logic [WIDTH-1:0] cmp_key,
   output logic [WORDS-1:0] hit_now,
   input  logic [ROW_W-1:0] pick_row,
   output logic [WIDTH-1:0] pick_word
);
   logic [WIDTH-1:0] cells [WORDS];
   logic [WORDS-1:0] row_ok;

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_row] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     row_ok <= '0;
      else if (wr_en) row_ok[wr_row] <= 1'b1;
   end

   // per-row masked comparison, all rows in parallel
   for (genvar r = 0; r < WORDS; r++) begin : g_row
      logic [WIDTH-1:0] diff;
      assign diff       = (cells[r] ^ cmp_arg) & cmp_key;
      assign hit_now[r] = row_ok[r] & ~(|diff);
   end

   assign pick_word = cells[pick_row];
endmodule

// File: rtl/cam_scan.sv
module cam_scan
   import cam_pkg::*;
#(
   parameter int WORDS = 8,
   parameter int WIDTH = 16,
   localparam int ROW_W = $clog2(WORDS),
   localparam int CUR_W = ROW_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [WORDS-1:0] hit_vec,
   input  logic [WIDTH-1:0] word_in,
   output logic [ROW_W-1:0] pick_row,
   output logic             rd_valid,
   output logic [ROW_W-1:0] rd_row,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_done
);
   scan_state_t      state;
   logic [CUR_W-1:0] cursor;
   logic             found;

   // lowest set hit bit at or above the cursor
   always_comb begin
      found    = 1'b0;
      pick_row = '0;
      for (int i = WORDS - 1; i >= 0; i--) begin
         if (hit_vec[i] && (CUR_W'(i) >= cursor)) begin
            found    = 1'b1;
            pick_row = ROW_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SCAN_IDLE;
         cursor   <= '0;
         rd_valid <= 1'b0;
         rd_done  <= 1'b0;
         rd_row   <= '0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         rd_done  <= 1'b0;
         if (start) begin
            state  <= SCAN_RUN;
            cursor <= '0;
         end else if (abort) begin
            state <= SCAN_IDLE;
         end else if (state == SCAN_RUN) begin
            if (found) begin
               rd_valid <= 1'b1;
               rd_row   <= pick_row;
               rd_data  <= word_in;
               cursor   <= {1'b0, pick_row} + CUR_W'(1);
            end else begin
               rd_done <= 1'b1;
               state   <= SCAN_IDLE;
            end
         end
      end
   end
endmodule

// File: rtl/keyed_cam.sv
module keyed_cam #(
   parameter int WORDS = 8,
   parameter int WIDTH = 16,
   localparam int ROW_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             srch_en,
   input  logic [WIDTH-1:0] srch_arg,
   input  logic [WIDTH-1:0] srch_key,
   output logic             any_hit,
   output logic             rd_valid,
   output logic [ROW_W-1:0] rd_row,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_done
);
   if (WORDS < 2) begin : g_bad_words
      $error("keyed_cam: WORDS must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("keyed_cam: WIDTH must be at least 1");
   end

   logic [WORDS-1:0] hit_now;
   logic [WORDS-1:0] hit_q;
   logic [ROW_W-1:0] pick_row;
   logic [WIDTH-1:0] pick_word;

   cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_row   (wr_row),
      .wr_data  (wr_data),
      .cmp_arg  (srch_arg),
      .cmp_key  (srch_key),
      .hit_now  (hit_now),
      .pick_row (pick_row),
      .pick_word(pick_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       hit_q <= '0;
      else if (srch_en) hit_q <= hit_now;
   end

   assign any_hit = |hit_q;

   cam_scan #(.WORDS(WORDS), .WIDTH(WIDTH)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (srch_en),
      .abort    (wr_en),
      .hit_vec  (hit_q),
      .word_in  (pick_word),
      .pick_row (pick_row),
      .rd_valid (rd_valid),
      .rd_row   (rd_row),
      .rd_data  (rd_data),
      .rd_done  (rd_done)
   );
endmodule

// File: rtl/cam_chk.sv
module cam_chk #(
   parameter int WORDS = 8,
   localparam int ROW_W = $clog2(WORDS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srch_en,
   input logic             wr_en,
   input logic [WORDS-1:0] hit_q,
   input logic             rd_valid,
   input logic [ROW_W-1:0] rd_row,
   input logic             rd_done
);
   a_r6_rising_rows: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid)) |-> (rd_row > $past(rd_row)));

   a_r6_row_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> hit_q[rd_row]);

   a_r7_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && rd_done));

   a_r8_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && !$past(srch_en)) |-> (!rd_valid && !rd_done));

   a_r9_hits_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(srch_en) |-> $stable(hit_q));
endmodule

bind keyed_cam cam_chk #(.WORDS(WORDS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .srch_en (srch_en),
   .wr_en   (wr_en),
   .hit_q   (hit_q),
   .rd_valid(rd_valid),
   .rd_row  (rd_row),
   .rd_done (rd_done)
);

// File: tb/tb_keyed_cam.sv
module tb_keyed_cam;
   localparam int WORDS = 8;
   localparam int WIDTH = 16;
   localparam int ROW_W = $clog2(WORDS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [ROW_W-1:0] wr_row = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             srch_en = 1'b0;
   logic [WIDTH-1:0] srch_arg = '0;
   logic [WIDTH-1:0] srch_key = '0;
   logic             any_hit;
   logic             rd_valid;
   logic [ROW_W-1:0] rd_row;
   logic [WIDTH-1:0] rd_data;
   logic             rd_done;

   always #5 clk = ~clk;

   keyed_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) dut (.*);

   typedef struct {
      bit         done;
      int         row;
      logic [WIDTH-1:0] data;
      string      req;
   } item_t;

   item_t            sb[$];
   item_t            cur;
   logic [WIDTH-1:0] model_mem [WORDS];
   bit               model_ok  [WORDS];
   int               n_run = 0;
   int               n_fail = 0;
   bit               reported = 0;

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      end
      $finish;
   endtask

   // monitor: pops one expected item per output event
   always @(negedge clk) begin
      if (rst_n && (rd_valid || rd_done)) begin
         if (sb.size() == 0) begin
            chk(0, "R8 unexpected output", {14'd0, rd_valid, rd_done, rd_data}, 32'd0);
         end else begin
            cur = sb.pop_front();
            if (cur.done)
               chk(rd_done && !rd_valid, {cur.req, " R7 done"},
                   {30'd0, rd_valid, rd_done}, 32'd1);
            else
               chk(rd_valid && !rd_done && (int'(rd_row) == cur.row) && (rd_data == cur.data),
                   {cur.req, " R6 row/data"},
                   {7'd0, rd_done, 8'(rd_row), rd_data},
                   {8'd0, 8'(cur.row), cur.data});
         end
      end
   end

   // all tasks start and end just after a falling edge
   task automatic wr(input int row, input logic [WIDTH-1:0] d);
      wr_en = 1'b1; wr_row = ROW_W'(row); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_mem[row] = d;
      model_ok[row]  = 1;
   endtask

   task automatic srch(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k,
                       input int limit, input string req);
      int cnt = 0;
      item_t it;
      for (int r = 0; r < WORDS; r++) begin
         if (model_ok[r] && (((model_mem[r] ^ a) & k) == '0)) begin
            if (limit < 0 || cnt < limit) begin
               it.done = 0; it.row = r; it.data = model_mem[r]; it.req = req;
               sb.push_back(it);
            end
            cnt++;
         end
      end
      if (limit < 0) begin
         it.done = 1; it.row = 0; it.data = '0; it.req = req;
         sb.push_back(it);
      end
      srch_en = 1'b1; srch_arg = a; srch_key = k;
      @(negedge clk);
      srch_en = 1'b0;
      chk(any_hit == (cnt > 0), {req, " R5 any_hit"}, 32'(any_hit), 32'(cnt > 0));
   endtask

   task automatic drain(input string req);
      int t = 0;
      while (sb.size() != 0 && t < 40) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, {req, " R7 scoreboard empty"}, 32'(sb.size()), 32'd0);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      chk(0, "watchdog", 32'd1, 32'd0);
      report();
   end

   initial begin
      for (int r = 0; r < WORDS; r++) begin
         model_mem[r] = '0;
         model_ok[r]  = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!any_hit && !rd_valid && !rd_done, "R1 reset state",
          {29'd0, any_hit, rd_valid, rd_done}, 32'd0);

      // nothing written: no match, done at once (R4, R7)
      srch(16'h0000, 16'h0000, -1, "R4 empty array");
      drain("R4");

      for (int r = 0; r < 6; r++) wr(r, 16'h1200 | WIDTH'(r * 'h11));

      srch(16'h1233, 16'hFFFF, -1, "R2 R3 exact");
      drain("R3");
      srch(16'h12EE, 16'hFF00, -1, "R3 upper byte");
      drain("R3");
      srch(16'hBEEF, 16'h0000, -1, "R4 zero key skips unwritten rows");
      drain("R4");
      srch(16'h0005, 16'h000F, -1, "R3 low nibble");
      drain("R3");
      srch(16'h1344, 16'h00FF, -1, "R3 unmasked differences");
      drain("R3");

      wr(7, 16'h1255);
      wr(6, 16'h0000);
      srch(16'h1255, 16'hFFFF, -1, "R6 last row");
      drain("R6");

      // R9: writes do not disturb the hit register
      wr(5, 16'hFFFF);
      wr(7, 16'hFFFF);
      chk(any_hit == 1'b1, "R9 hit held over writes", 32'(any_hit), 32'd1);
      srch(16'h1255, 16'hFFFF, -1, "R9 now absent");
      drain("R9");
      wr(1, 16'h1255);
      chk(any_hit == 1'b0, "R9 miss held over write", 32'(any_hit), 32'd0);

      // R8: write aborts a running scan after the first result
      srch(16'h0000, 16'h0000, 1, "R8 write abort");
      @(negedge clk);
      wr(0, 16'h0BAD);
      drain("R8 write");

      // R8: a new search restarts the read-out
      srch(16'h0000, 16'h0000, 2, "R8 search abort");
      @(negedge clk);
      @(negedge clk);
      srch(16'h1255, 16'hFFFF, -1, "R8 restarted");
      drain("R8 search");

      report();
   end
endmodule